// File: doc/BRIEF.md
# Interrupt Request Input Conditioner

This block sits between two asynchronous interrupt pins and a processor core. Both pins are brought into the system clock domain first. The non-maskable pin is edge-qualified: a rising edge only counts if the synchronized level was low for a minimum run of system clocks before it. Once qualified, the edge sets a pending flag. That flag stays set until the core takes the interrupt, and further edges while it is set merge into the same request. The maskable pin is a level. The block samples it once per processor cycle, on the cycle-start strobe, gated by the interrupt-enable flag. It becomes eligible only after enough consecutive active samples.

At each instruction boundary the block picks at most one interrupt and issues a one-cycle grant. The non-maskable request always wins. Its grant carries a fixed internal vector and asks for no acknowledge bus cycles, whatever the enable flag says. A maskable grant tells the core to run two acknowledge bus cycles to fetch an 8-bit vector from outside. Running those cycles is the core's job.

Top module: `irq_cond`

## Requirements
- R1: While reset is asserted, and on the first sample after it, irq_take, irq_nmi, vec_internal, nmi_pending and intr_pending are 0, and vec_num and ack_cycles are 0.
- R2: Each pin passes through two synchronizer flops. A qualifying rising edge on nmi_in shows on nmi_pending after the third rising clock edge that samples the new level, and not after the second.
- R3: A rising edge of the synchronized non-maskable level sets nmi_pending only if that level was low for at least 4 consecutive system clocks just before it. A run of 3 low clocks is ignored.
- R4: nmi_pending stays set until a non-maskable grant is issued. Extra qualified edges while it is set produce a single grant only.
- R5: A non-maskable grant has irq_nmi=1, vec_internal=1, vec_num=2 and ack_cycles=0, and it is issued whatever the value of if_flag.
- R6: intr_pending is 0 whenever if_flag is 0, and no maskable grant is issued while if_flag is 0.
- R7: On each cycle_start strobe, intr_in (synchronized) AND if_flag is sampled. intr_pending becomes 1 only after 2 consecutive active samples. An inactive sample restarts the count, and so does a maskable grant.
- R8: A maskable grant has irq_nmi=0, vec_internal=0, vec_num=0 and ack_cycles=2.
- R9: When both are pending at a boundary, the non-maskable request is granted. The maskable one stays pending for a later boundary.
- R10: irq_take is a one-cycle pulse. It is registered on the clock that samples instr_end high with a request pending, and it never appears otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start | input | 1 | Strobe marking the start of a processor cycle |
| nmi_in | input | 1 | Asynchronous non-maskable interrupt pin |
| intr_in | input | 1 | Asynchronous maskable interrupt pin, active high |
| if_flag | input | 1 | Interrupt-enable flag from the core |
| instr_end | input | 1 | Instruction boundary: a grant may be issued now |
| irq_take | output | 1 | One-cycle grant pulse |
| irq_nmi | output | 1 | Grant is the non-maskable interrupt |
| vec_internal | output | 1 | Vector is supplied internally, with no acknowledge cycles |
| vec_num | output | 8 | Internal vector number (2 for the non-maskable interrupt) |
| ack_cycles | output | 2 | Number of acknowledge bus cycles the core must run |
| nmi_pending | output | 1 | Qualified non-maskable request waiting |
| intr_pending | output | 1 | Maskable request eligible at the next boundary |

## Verification
A miscounted low-run counter either lets short glitches through or drops real edges, and it shows on nmi_pending three clocks after the rising edge. A pending flag that clears itself, or sets twice, shows as a missing or an extra grant at the next instr_end. A wrong sample counter or a missing mask shows on intr_pending as soon as a cycle_start strobe lands, or as soon as if_flag changes. The bench runs a clock-level reference alongside the block and compares every output on every cycle, so any such fault is reported in the cycle it appears.

// File: rtl/irq_cond.sv
module irq_cond #(
  parameter int SYNC_STAGES  = 2,
  parameter int LOW_MIN      = 4,
  parameter int INTR_SAMPLES = 2,
  parameter int NMI_VEC      = 2,
  parameter int ACK_CYCLES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cycle_start,
  input  logic       nmi_in,
  input  logic       intr_in,
  input  logic       if_flag,
  input  logic       instr_end,
  output logic       irq_take,
  output logic       irq_nmi,
  output logic       vec_internal,
  output logic [7:0] vec_num,
  output logic [1:0] ack_cycles,
  output logic       nmi_pending,
  output logic       intr_pending
);
  localparam int LW = $clog2(LOW_MIN + 1);
  localparam int IW = $clog2(INTR_SAMPLES + 1);

  logic [SYNC_STAGES-1:0] nmi_sh, intr_sh;
  logic          nmi_prev;
  logic [LW-1:0] low_run;
  logic [IW-1:0] act_run;

  wire nmi_s      = nmi_sh[SYNC_STAGES-1];
  wire intr_s     = intr_sh[SYNC_STAGES-1];
  wire nmi_edge   = nmi_s & ~nmi_prev & (low_run >= LW'(LOW_MIN));
  wire grant_nmi  = instr_end & nmi_pending;
  wire grant_intr = instr_end & ~nmi_pending & intr_pending;

  assign intr_pending = (act_run == IW'(INTR_SAMPLES)) & if_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_sh   <= '0;
      intr_sh  <= '0;
      nmi_prev <= 1'b0;
      low_run  <= '0;
    end else begin
      nmi_sh   <= {nmi_sh[SYNC_STAGES-2:0], nmi_in};
      intr_sh  <= {intr_sh[SYNC_STAGES-2:0], intr_in};
      nmi_prev <= nmi_s;
      if (nmi_s)
        low_run <= '0;
      else if (low_run < LW'(LOW_MIN))
        low_run <= low_run + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      nmi_pending <= 1'b0;
    else if (nmi_edge)
      nmi_pending <= 1'b1;
    else if (grant_nmi)
      nmi_pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      act_run <= '0;
    else if (grant_intr)
      act_run <= '0;
    else if (cycle_start) begin
      if (!(intr_s & if_flag))
        act_run <= '0;
      else if (act_run < IW'(INTR_SAMPLES))
        act_run <= act_run + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_take     <= 1'b0;
      irq_nmi      <= 1'b0;
      vec_internal <= 1'b0;
      vec_num      <= '0;
      ack_cycles   <= '0;
    end else begin
      irq_take     <= grant_nmi | grant_intr;
      irq_nmi      <= grant_nmi;
      vec_internal <= grant_nmi;
      vec_num      <= grant_nmi ? 8'(NMI_VEC) : 8'd0;
      ack_cycles   <= grant_intr ? 2'(ACK_CYCLES) : 2'd0;
    end
  end

  assert_take_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(instr_end));
  assert_nmi_grant_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_nmi) |-> (vec_internal && vec_num == 8'(NMI_VEC) && ack_cycles == 2'd0));
  assert_intr_grant_form_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !irq_nmi) |-> (!vec_internal && ack_cycles == 2'(ACK_CYCLES)));
  assert_intr_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !irq_nmi) |-> $past(if_flag));
  assert_nmi_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_end && nmi_pending) |=> (irq_take && irq_nmi));
  assert_nmi_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pending && !instr_end) |=> nmi_pending);
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && !$past(instr_end && (nmi_pending || intr_pending))) |-> 1'b0);
endmodule

// File: tb/sim_irq_cond.sv
module sim_irq_cond;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycle_start = 1'b0, nmi_in = 1'b0, intr_in = 1'b0, if_flag = 1'b0, instr_end = 1'b0;
  logic irq_take, irq_nmi, vec_internal, nmi_pending, intr_pending;
  logic [7:0] vec_num;
  logic [1:0] ack_cycles;

  int checks = 0, errors = 0;
  bit done = 0, cmp_on = 0;

  always #10 clk = ~clk;

  irq_cond u0 (.clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .nmi_in(nmi_in),
    .intr_in(intr_in), .if_flag(if_flag), .instr_end(instr_end), .irq_take(irq_take),
    .irq_nmi(irq_nmi), .vec_internal(vec_internal), .vec_num(vec_num),
    .ack_cycles(ack_cycles), .nmi_pending(nmi_pending), .intr_pending(intr_pending));

  // clock-level reference built from the requirements
  bit m_n1, m_n2, m_nprev, m_i1, m_i2, m_np, m_take, m_nmi;
  int m_low, m_cnt;

  function automatic bit nmi_qualifies(bit cur, bit prev, int low_run);
    return cur && !prev && low_run >= 4;
  endfunction
  function automatic bit intr_ready(int cnt, bit ifl);
    return cnt >= 2 && ifl;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_n1 <= 0; m_n2 <= 0; m_nprev <= 0; m_i1 <= 0; m_i2 <= 0;
      m_np <= 0; m_take <= 0; m_nmi <= 0; m_low <= 0; m_cnt <= 0;
    end else begin
      bit gn, gi;
      gn = instr_end && m_np;
      gi = instr_end && !m_np && intr_ready(m_cnt, if_flag);
      m_n1 <= nmi_in; m_n2 <= m_n1; m_nprev <= m_n2;
      m_i1 <= intr_in; m_i2 <= m_i1;
      m_low <= m_n2 ? 0 : (m_low < 4 ? m_low + 1 : 4);
      if (nmi_qualifies(m_n2, m_nprev, m_low)) m_np <= 1;
      else if (gn) m_np <= 0;
      if (gi) m_cnt <= 0;
      else if (cycle_start) m_cnt <= (m_i2 && if_flag) ? (m_cnt < 2 ? m_cnt + 1 : 2) : 0;
      m_take <= gn || gi;
      m_nmi <= gn;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #8;
    if (cmp_on && !done) begin
      chk(irq_take == m_take, "R10 irq_take", irq_take, m_take);
      chk(irq_nmi == m_nmi, "R9 irq_nmi", irq_nmi, m_nmi);
      chk(vec_internal == m_nmi && vec_num == (m_nmi ? 2 : 0), "R5 vector", vec_num, m_nmi ? 2 : 0);
      chk(ack_cycles == ((m_take && !m_nmi) ? 2 : 0), "R8 ack_cycles", ack_cycles, (m_take && !m_nmi) ? 2 : 0);
      chk(nmi_pending == m_np, "R3 nmi_pending", nmi_pending, m_np);
      chk(intr_pending == intr_ready(m_cnt, if_flag), "R7 intr_pending", intr_pending, intr_ready(m_cnt, if_flag));
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic settle;
    @(posedge clk); #8;
  endtask
  task automatic nmi_pulse(int low);
    nmi_in = 0; step(low); nmi_in = 1;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    settle;
    chk(irq_take == 0 && irq_nmi == 0 && vec_internal == 0 && vec_num == 0 && ack_cycles == 0
        && nmi_pending == 0 && intr_pending == 0, "R1 reset outputs", irq_take, 0);
    @(negedge clk); rst_n = 1;
    settle;
    chk(nmi_pending == 0 && irq_take == 0, "R1 first sample", nmi_pending, 0);
    cmp_on = 1;

    // R3: three low clocks are rejected
    @(negedge clk); nmi_in = 1; step(8);
    nmi_pulse(3); step(8);
    chk(nmi_pending == 0, "R3 short low run", nmi_pending, 0);
    // R2/R3: four low clocks qualify, seen after the third edge
    nmi_pulse(4);
    settle; settle;
    chk(nmi_pending == 0, "R2 not after two edges", nmi_pending, 0);
    settle;
    chk(nmi_pending == 1, "R2 R3 set after third edge", nmi_pending, 1);
    // R4: second qualified edge while pending merges
    @(negedge clk); nmi_pulse(4); step(8);
    chk(nmi_pending == 1, "R4 still pending", nmi_pending, 1);
    if_flag = 0; instr_end = 1;
    settle;
    chk(irq_take && irq_nmi && vec_internal && vec_num == 2 && ack_cycles == 0, "R5 nmi grant with IF clear", vec_num, 2);
    @(negedge clk); instr_end = 0;
    settle;
    chk(irq_take == 0, "R10 single cycle pulse", irq_take, 0);
    step(6); instr_end = 1;
    settle;
    chk(irq_take == 0, "R4 no second grant", irq_take, 0);
    @(negedge clk); instr_end = 0;

    // R7: two consecutive samples
    if_flag = 1; intr_in = 1; step(4);
    cycle_start = 1; settle;
    @(negedge clk); cycle_start = 0;
    settle;
    chk(intr_pending == 0, "R7 one sample", intr_pending, 0);
    @(negedge clk); cycle_start = 1; settle;
    @(negedge clk); cycle_start = 0;
    settle;
    chk(intr_pending == 1, "R7 two samples", intr_pending, 1);
    // R6: mask
    @(negedge clk); if_flag = 0; instr_end = 1;
    settle;
    chk(intr_pending == 0, "R6 masked pending", intr_pending, 0);
    @(negedge clk);
    chk(irq_take == 0, "R6 no grant while masked", irq_take, 0);
    instr_end = 0; if_flag = 1;
    settle;
    chk(intr_pending == 1, "R6 unmasked again", intr_pending, 1);

    // R9 then R8
    @(negedge clk); nmi_pulse(5); step(5);
    instr_end = 1;
    settle;
    chk(irq_take && irq_nmi, "R9 nmi wins", irq_nmi, 1);
    chk(intr_pending == 1, "R9 intr kept", intr_pending, 1);
    settle;
    chk(irq_take && !irq_nmi && !vec_internal && ack_cycles == 2 && vec_num == 0, "R8 intr grant", ack_cycles, 2);
    chk(intr_pending == 0, "R7 count restarts after grant", intr_pending, 0);
    @(negedge clk); instr_end = 0; intr_in = 0;
    step(4);

    // random phase, compared cycle by cycle against the reference
    void'($urandom(32'h1d4c));
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      cycle_start = c[0];
      if ($urandom_range(5) == 0) nmi_in = ~nmi_in;
      if ($urandom_range(9) == 0) intr_in = ~intr_in;
      if ($urandom_range(19) == 0) if_flag = ~if_flag;
      instr_end = ($urandom_range(5) == 0);
    end
    @(negedge clk); instr_end = 0; cycle_start = 0;
    step(2);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule